// File: doc/BRIEF.md
# UART Receiver Mute and Wake-Up

This block sits beside a UART receiver on a multi-drop line. It lets a node that is not being addressed ignore the traffic on the line. Software raises a mute request, and the block enters a sleep state. While asleep, the block discards received characters, forces the receiver's status-flag set pulses to zero and keeps every receive interrupt low. Meanwhile it watches for a wake condition, and a mode input selects which one counts. With the mode input at 0, the condition is a whole frame time of continuously high line. With the mode input at 1, the condition is a character whose top data bit is set, which marks it as an address.

Characters come from the receiver core as a valid/ready stream, and the block passes them on as a valid/ready stream. When the node is awake, the stream passes straight through and back-pressure from the sink reaches the source unchanged. When the node is muted, the block accepts each character at once (`in_ready` high) and drops it. The one exception is a waking address character: it is forwarded with normal back-pressure. The mute state ends when the sink accepts that character. The receiver core itself and any compare against the node's own address are outside this block.

Top module: `uart_rx_mute`

## Requirements
- R1: After reset the block is awake (`mute_status` = 0) and the stream, status flags and interrupts pass through.
- R2: A `mute_set` pulse while awake, without `mute_clr`, makes `mute_status` read 1 from the next cycle.
- R3: While muted, `stat_set_out` is all zeros, except in the cycle a waking address character is presented.
- R4: While muted, `irq_out` is all zeros, except in the cycle a waking address character is presented.
- R5: While muted, a character that does not wake the block is dropped: `in_ready` = 1 and `out_valid` = 0.
- R6: With `wake_addr` = 0, after at least one low sampled bit since muting, a run of consecutive high `bit_tick` samples of one frame length clears `mute_status` in the cycle after the last such tick. A low sample restarts the run.
- R7: The frame length is DATA_W+2 bit periods when `long_word` = 0 and DATA_W+3 when `long_word` = 1. With the default DATA_W = 8, these are 10 and 11.
- R8: A line that stays high from the moment of muting, with no low sample, never wakes the block.
- R9: With `wake_addr` = 1, a character whose bit DATA_W-1 (bit 7 by default) is 1 is forwarded with its status flags and interrupts. `mute_status` clears in the cycle after the sink accepts it.
- R10: Idle-line wake is ignored when `wake_addr` = 1. Address characters do not wake the block when `wake_addr` = 0.
- R11: `mute_clr` clears `mute_status` on the next cycle whatever else happens, and wins over a simultaneous `mute_set`.
- R12: While awake, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and `out_data` equals `in_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mute_set | input | 1 | Software request to enter the sleep state |
| mute_clr | input | 1 | Software forced wake-up |
| wake_addr | input | 1 | Wake mode: 0 idle line, 1 address mark |
| long_word | input | 1 | Word length select: adds one bit to the frame |
| bit_tick | input | 1 | Strobe, one per bit time, qualifying `line_bit` |
| line_bit | input | 1 | Sampled receive line level |
| in_valid | input | 1 | Received character valid from the core |
| in_ready | output | 1 | Character accepted |
| in_data | input | DATA_W | Received character |
| out_valid | output | 1 | Delivered character valid |
| out_ready | input | 1 | Sink accepts the character |
| out_data | output | DATA_W | Delivered character |
| stat_set_in | input | FLAG_W | Status-flag set pulses from the core |
| stat_set_out | output | FLAG_W | Gated status-flag set pulses |
| irq_in | input | IRQ_W | Receive interrupt requests from the core |
| irq_out | output | IRQ_W | Gated receive interrupt requests |
| mute_status | output | 1 | Current mute state, readable by software |

## Verification
For both word lengths, the idle-line wake is swept over every run length from zero to beyond the frame, after one low bit. This pins down the exact tick count at which wake occurs, and a low bit in the middle of a run is shown to restart the count. A muted line that stays high throughout separates armed counting from counting that starts at once. Every one of the 256 character values is presented in each wake mode. This shows that only the top data bit wakes the block, and only in address mode. It also shows that the waking character alone carries flags and interrupts through. Set/clear collisions and back-pressure checks while awake and on a waking character complete the coverage.

// File: rtl/uart_mute_pkg.sv
package uart_mute_pkg;

  // Frame length in bit periods: start + data + optional extra bit + stop.
  function automatic int frame_bits(input int data_w, input logic long_word);
    return data_w + 2 + (long_word ? 1 : 0);
  endfunction

endpackage

// File: rtl/mute_idle_detect.sv
module mute_idle_detect #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic muted,
  input  logic long_word,
  input  logic bit_tick,
  input  logic line_bit,
  output logic idle_hit
);
  import uart_mute_pkg::*;

  localparam int FRAME_MAX = DATA_W + 3;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  logic             armed;
  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] last_idx;

  assign last_idx = CNT_W'(frame_bits(DATA_W, long_word) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      armed   <= 1'b0;
      run_cnt <= '0;
    end else if (muted && bit_tick) begin
      if (!line_bit) begin
        armed   <= 1'b1;
        run_cnt <= '0;
      end else if (armed && run_cnt != last_idx) begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  assign idle_hit = muted && armed && bit_tick && line_bit && (run_cnt == last_idx);

endmodule

// File: rtl/mute_stream_gate.sv
module mute_stream_gate #(
  parameter int DATA_W = 8,
  parameter int FLAG_W = 4,
  parameter int IRQ_W  = 2
) (
  input  logic              muted,
  input  logic              wake_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic [FLAG_W-1:0] stat_set_in,
  output logic [FLAG_W-1:0] stat_set_out,
  input  logic [IRQ_W-1:0]  irq_in,
  output logic [IRQ_W-1:0]  irq_out,
  output logic              addr_wake
);
  logic addr_mark;
  logic wake_char;
  logic pass;

  assign addr_mark = in_data[DATA_W-1];
  assign wake_char = muted && wake_addr && in_valid && addr_mark;
  assign pass      = !muted || wake_char;

  assign out_valid    = in_valid && pass;
  assign out_data     = in_data;
  assign in_ready     = pass ? out_ready : 1'b1;
  assign stat_set_out = pass ? stat_set_in : '0;
  assign irq_out      = pass ? irq_in : '0;
  assign addr_wake    = wake_char && out_ready;

endmodule

// File: rtl/uart_rx_mute.sv
module uart_rx_mute #(
  parameter int DATA_W = 8,
  parameter int FLAG_W = 4,
  parameter int IRQ_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mute_set,
  input  logic              mute_clr,
  input  logic              wake_addr,
  input  logic              long_word,
  input  logic              bit_tick,
  input  logic              line_bit,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic [FLAG_W-1:0] stat_set_in,
  output logic [FLAG_W-1:0] stat_set_out,
  input  logic [IRQ_W-1:0]  irq_in,
  output logic [IRQ_W-1:0]  irq_out,
  output logic              mute_status
);
  logic muted;
  logic idle_hit;
  logic addr_wake;
  logic wake;
  logic entering;

  assign entering = mute_set && !muted && !mute_clr;
  assign wake     = addr_wake || (idle_hit && !wake_addr);

  always_ff @(posedge clk) begin
    if (!rst_n)        muted <= 1'b0;
    else if (mute_clr) muted <= 1'b0;
    else if (wake)     muted <= 1'b0;
    else if (mute_set) muted <= 1'b1;
  end

  mute_idle_detect #(.DATA_W(DATA_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .restart(entering), .muted(muted),
    .long_word(long_word), .bit_tick(bit_tick), .line_bit(line_bit),
    .idle_hit(idle_hit)
  );

  mute_stream_gate #(.DATA_W(DATA_W), .FLAG_W(FLAG_W), .IRQ_W(IRQ_W)) u_gate (
    .muted(muted), .wake_addr(wake_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .stat_set_in(stat_set_in), .stat_set_out(stat_set_out),
    .irq_in(irq_in), .irq_out(irq_out), .addr_wake(addr_wake)
  );

  assign mute_status = muted;

endmodule

// File: rtl/uart_rx_mute_chk.sv
module uart_rx_mute_chk #(
  parameter int DATA_W = 8,
  parameter int FLAG_W = 4,
  parameter int IRQ_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mute_set,
  input logic              mute_clr,
  input logic              wake_addr,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [FLAG_W-1:0] stat_set_out,
  input logic [IRQ_W-1:0]  irq_out,
  input logic              mute_status
);
  logic waking;
  assign waking = wake_addr && in_valid && in_data[DATA_W-1];

  assert_enter_mute_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_set && !mute_clr && !mute_status) |=> mute_status);

  assert_flags_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_status && !waking) |-> (stat_set_out == '0));

  assert_irq_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_status && !waking) |-> (irq_out == '0));

  assert_drop_char_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_status && in_valid && !waking) |-> (in_ready && !out_valid));

  assert_addr_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_status && waking && out_ready && !mute_clr) |=> !mute_status);

  assert_force_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mute_clr |=> !mute_status);

  assert_passthru_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_status |-> (out_valid == in_valid && in_ready == out_ready && out_data == in_data));

endmodule

bind uart_rx_mute uart_rx_mute_chk #(.DATA_W(DATA_W), .FLAG_W(FLAG_W), .IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mute_set(mute_set), .mute_clr(mute_clr),
  .wake_addr(wake_addr), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .stat_set_out(stat_set_out), .irq_out(irq_out),
  .mute_status(mute_status)
);

// File: tb/test_uart_rx_mute.sv
`timescale 1ns/1ps
module test_uart_rx_mute;
  localparam int DW = 8, FW = 4, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mute_set = 0, mute_clr = 0, wake_addr = 0, long_word = 0;
  logic bit_tick = 0, line_bit = 1;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1, mute_status;
  logic [DW-1:0] in_data = '0, out_data;
  logic [FW-1:0] stat_set_in = '1, stat_set_out;
  logic [IW-1:0] irq_in = '1, irq_out;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  uart_rx_mute #(.DATA_W(DW), .FLAG_W(FW), .IRQ_W(IW)) i_uart_rx_mute (
    .clk(clk), .rst_n(rst_n), .mute_set(mute_set), .mute_clr(mute_clr),
    .wake_addr(wake_addr), .long_word(long_word), .bit_tick(bit_tick),
    .line_bit(line_bit), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .stat_set_in(stat_set_in), .stat_set_out(stat_set_out),
    .irq_in(irq_in), .irq_out(irq_out), .mute_status(mute_status)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_set();
    mute_set = 1; @(negedge clk); mute_set = 0;
  endtask
  task automatic pulse_clr();
    mute_clr = 1; @(negedge clk); mute_clr = 0;
  endtask
  task automatic tick(input logic v);
    bit_tick = 1; line_bit = v; @(negedge clk); bit_tick = 0; line_bit = 1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state, pass-through
    chk("R1 mute", mute_status, 0);
    in_valid = 1; in_data = 8'h5A; #1;
    chk("R1 valid", out_valid, 1);
    chk("R1 flags", stat_set_out, 4'hF);
    chk("R1 irq", irq_out, 2'b11);
    // R12: back-pressure while awake
    out_ready = 0; #1;
    chk("R12 ready low", in_ready, 0);
    chk("R12 data", out_data, 8'h5A);
    out_ready = 1; #1;
    chk("R12 ready high", in_ready, 1);
    in_valid = 0; #1;
    chk("R12 valid low", out_valid, 0);
    @(negedge clk);

    // R2/R3/R4/R11
    pulse_set();
    chk("R2 muted", mute_status, 1);
    chk("R3 flags gated", stat_set_out, 0);
    chk("R4 irq gated", irq_out, 0);
    mute_set = 1; mute_clr = 1; @(negedge clk); mute_set = 0; mute_clr = 0;
    chk("R11 clr wins", mute_status, 0);
    pulse_set();
    pulse_clr();
    chk("R11 forced wake", mute_status, 0);

    // R6/R7: idle run sweep for both word lengths
    for (int lw = 0; lw < 2; lw++) begin
      for (int n = 0; n <= 13; n++) begin
        wake_addr = 0; long_word = lw[0];
        pulse_clr(); pulse_set();
        tick(1'b0);
        for (int k = 0; k < n; k++) tick(1'b1);
        chk($sformatf("R6 R7 lw=%0d n=%0d", lw, n), mute_status,
            (n >= DW + 2 + lw) ? 0 : 1);
      end
      // R6: low bit mid-run restarts the count
      pulse_clr(); pulse_set();
      tick(1'b0);
      for (int k = 0; k < DW + 1 + lw; k++) tick(1'b1);
      tick(1'b0);
      for (int k = 0; k < DW + 1 + lw; k++) tick(1'b1);
      chk("R6 restart", mute_status, 1);
      tick(1'b1);
      chk("R6 wake after restart", mute_status, 0);
    end

    // R8: already idle line
    long_word = 0; pulse_clr(); pulse_set();
    for (int k = 0; k < 30; k++) tick(1'b1);
    chk("R8 no low seen", mute_status, 1);

    // R10: idle ignored in address mode
    wake_addr = 1; pulse_clr(); pulse_set();
    tick(1'b0);
    for (int k = 0; k < 20; k++) tick(1'b1);
    chk("R10 idle ignored", mute_status, 1);

    // R9/R5/R10: sweep every character value in both modes
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 256; v++) begin
        logic wk;
        wk = (m == 1) && v[7];
        wake_addr = m[0];
        pulse_clr(); pulse_set();
        in_valid = 1; in_data = v[7:0]; #1;
        chk($sformatf("R5 R9 valid m=%0d v=%0d", m, v), out_valid, wk);
        chk($sformatf("R5 ready m=%0d v=%0d", m, v), in_ready, 1);
        chk($sformatf("R3 R9 flags m=%0d v=%0d", m, v), stat_set_out, wk ? 4'hF : 0);
        chk($sformatf("R4 R9 irq m=%0d v=%0d", m, v), irq_out, wk ? 2'b11 : 0);
        @(negedge clk); in_valid = 0;
        chk($sformatf("R9 R10 mute m=%0d v=%0d", m, v), mute_status, wk ? 0 : 1);
      end
    end

    // R9: waking character held by back-pressure keeps mute until accepted
    wake_addr = 1; pulse_clr(); pulse_set();
    out_ready = 0; in_valid = 1; in_data = 8'h81; #1;
    chk("R9 held ready", in_ready, 0);
    @(negedge clk);
    chk("R9 held mute", mute_status, 1);
    out_ready = 1; @(negedge clk); in_valid = 0;
    chk("R9 accepted", mute_status, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule